// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Controller

This block is the digital side of a small serial EEPROM slave. A host selects it with a chip-select line, clocks it with a slow serial clock and shifts instructions in on a data-in line. The block decodes them, reads or changes an internal array of 1024 bits, and answers on a data-out line. The data-out line is modelled as a data bit plus an output-enable bit. The array is seen either as 64 words of 16 bits or as 128 bytes, chosen by a width-select input. The three host pins are synchronised into the system clock domain, and all behaviour is sampled there.

Writes are locked after reset until an unlock instruction arrives. Write, erase, erase-all and write-all start a self-timed programming cycle when chip select falls. A cycle counter stands in for the cell programming time, with one length for single locations and a longer one for whole-array operations. While chip select is high after such a cycle has started, data-out reports busy (0) or ready (1). Shifting in a single 1 releases the line.

Top module: `mw_eeprom`

## Requirements
- R1: After reset, dout_en is 0, writes are locked and every array bit reads 1.
- R2: A frame starts at the first 1 seen on di at a rising sk edge while cs is high; leading 0s are skipped. Then come a 2-bit opcode and an address, 6 bits when org_x16=1 or 7 bits when org_x16=0. Write-type frames end with a 16-bit or 8-bit data field. All fields are sent MSB first.
- R3: Opcode 10 (read): on the sk rise carrying the last address bit, dout_en goes to 1 with dout=0. Each following rise then drives the next data bit, MSB first. The rise after the last data bit clears dout_en. In byte mode, address bit 0 = 0 selects bits 7:0 of word addr[6:1], and 1 selects bits 15:8.
- R4: Opcode 00 with the top two address bits 11 unlocks writes, and 00 there relocks them. Opcodes 01 and 11, and 00 with top bits 10 or 01, have no effect while locked. Reads work in both states.
- R5: Opcode 01 (write) replaces the whole addressed word or byte with the data field. No prior erase is needed.
- R6: Opcode 11 sets the addressed word or byte to all ones. Opcode 00 with top bits 10 sets every bit of the array to 1.
- R7: Opcode 00 with top bits 01 writes the data field to every location. In byte mode, both bytes of every word receive it.
- R8: A complete write-type frame starts its cycle when cs falls. The cycle lasts T_WORD clocks for a single location and T_ALL clocks for a whole-array operation, and the array changes at its end.
- R9: Once a cycle has started, dout_en is 1 while cs is high, and dout is 0 while busy and 1 when ready. A rising sk edge with di=1 clears dout_en.
- R10: Every instruction that completes while a cycle is busy is ignored.
- R11: If cs falls before a frame is complete, the frame is discarded and no cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data in, sampled on rising sk |
| org_x16 | input | 1 | 1 = 16-bit words, 0 = bytes (tie high by default) |
| dout | output | 1 | Serial data out (read data or busy/ready) |
| dout_en | output | 1 | Output enable for dout |

## Verification
Fixed-sequence cases drive each opcode in both widths against a locked and an unlocked array. They also cover frames preceded by leading zeros, frames cut short by chip select, and instructions issued while busy. These separate decode errors from enable-latch errors and from timing-gate errors. Status is sampled early in a cycle, just before the shorter cycle length and again just after the cycle ends. This tells a single-location cycle from a whole-array one and shows that the array changes only at the end. Seeded random writes then mix widths and addresses. Read-back in the other width against a byte model exposes lane-selection and word-mapping faults.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_READ, ST_HOLD
    } mw_state_e;

    typedef enum logic [2:0] {
        JOB_NONE, JOB_WRITE, JOB_ERASE, JOB_ERAL, JOB_WRAL
    } mw_job_e;

    localparam logic [1:0] OPC_EXT   = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_ERASE = 2'b11;

    localparam logic [1:0] SUB_LOCK   = 2'b00;
    localparam logic [1:0] SUB_FILL   = 2'b01;
    localparam logic [1:0] SUB_CLRALL = 2'b10;
    localparam logic [1:0] SUB_UNLOCK = 2'b11;
endpackage

// File: rtl/mw_pin_sync.sv
module mw_pin_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] pin_o
);
    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        logic [STAGES-1:0] chain_d;
        always_comb chain_d = {chain_q[STAGES-2:0], pin_i[b]};
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= chain_d;
        end
        assign pin_o[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
    parameter int T_SHORT = 1000000,
    parameter int T_LONG  = 2000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic long_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CNT_W = $clog2(T_LONG + 1);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             busy_q, busy_d;

    always_comb begin
        cnt_d  = cnt_q;
        busy_d = busy_q;
        done_o = busy_q && (cnt_q == '0);
        if (start_i) begin
            busy_d = 1'b1;
            cnt_d  = long_i ? CNT_W'(T_LONG - 1) : CNT_W'(T_SHORT - 1);
        end else if (busy_q) begin
            if (cnt_q == '0) busy_d = 1'b0;
            else             cnt_d  = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            busy_q <= busy_d;
        end
    end

    assign busy_o = busy_q;

    // R10: the controller never launches a cycle on top of a running one
    a_r10_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_q);
    // R8: a running cycle counts down one per clock without stalling
    a_r8_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/mw_store.sv
module mw_store #(
    parameter int WORDS  = 64,
    parameter int WORD_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     wr_all,
    input  logic [$clog2(WORDS)-1:0] wr_addr,
    input  logic [WORD_W-1:0]        wr_mask,
    input  logic [WORD_W-1:0]        wr_data,
    input  logic [$clog2(WORDS)-1:0] rd_addr,
    output logic [WORD_W-1:0]        rd_data
);
    localparam int WA = $clog2(WORDS);

    logic [WORD_W-1:0] mem_q [WORDS];
    logic [WORD_W-1:0] mem_d [WORDS];

    always_comb begin
        for (int w = 0; w < WORDS; w++) begin
            mem_d[w] = mem_q[w];
            if (wr_en && (wr_all || wr_addr == WA'(w)))
                mem_d[w] = (mem_q[w] & ~wr_mask) | (wr_data & wr_mask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) mem_q[w] <= '1;
        end else begin
            for (int w = 0; w < WORDS; w++) mem_q[w] <= mem_d[w];
        end
    end

    assign rd_data = mem_q[rd_addr];

    // R7: a full-mask whole-array store reaches the first and last words
    a_r7_fill_reaches_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_all && (&wr_mask)) |=>
            (mem_q[0] == $past(wr_data) && mem_q[WORDS-1] == $past(wr_data)));
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
    import mw_eeprom_pkg::*;
#(
    parameter int WORDS       = 64,
    parameter int WORD_W      = 16,
    parameter int T_WORD      = 1000000,
    parameter int T_ALL       = 2000000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    input  logic org_x16,
    output logic dout,
    output logic dout_en
);
    localparam int WA     = $clog2(WORDS);
    localparam int BA     = WA + 1;
    localparam int BYTE_W = WORD_W / 2;
    localparam int CW     = $clog2(WORD_W + 1);

    typedef struct packed {
        mw_state_e         st;
        logic [CW-1:0]     cnt;
        logic [1:0]        opc;
        logic [BA-1:0]     adr;
        logic [WORD_W-1:0] dat;
        logic [WORD_W-1:0] shr;
        mw_job_e           pend;
        logic              wen;
        logic              stat;
        logic              sk_prev;
        logic              dout;
        logic              doe;
        logic [WA-1:0]     jword;
        logic [WORD_W-1:0] jmask;
        logic [WORD_W-1:0] jdata;
        logic              jall;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic [2:0]        pins_s;
    logic              cs_s, sk_s, di_s, org_s;
    logic              sk_rise;
    logic              tmr_start, tmr_long, tmr_busy, tmr_done;
    logic [WA-1:0]     rd_word;
    logic [WORD_W-1:0] rd_data;
    logic [BA-1:0]     adr_nx;
    logic [WORD_W-1:0] dat_nx;
    logic [1:0]        sub;
    logic [CW-1:0]     aw_len, dw_len;
    logic [BYTE_W-1:0] rd_byte;

    mw_pin_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({cs, sk, di}),
        .pin_o (pins_s)
    );
    assign cs_s  = pins_s[2];
    assign sk_s  = pins_s[1];
    assign di_s  = pins_s[0];
    assign org_s = org_x16;

    mw_prog_timer #(.T_SHORT(T_WORD), .T_LONG(T_ALL)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tmr_start),
        .long_i  (tmr_long),
        .busy_o  (tmr_busy),
        .done_o  (tmr_done)
    );

    mw_store #(.WORDS(WORDS), .WORD_W(WORD_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tmr_done),
        .wr_all  (ctl_q.jall),
        .wr_addr (ctl_q.jword),
        .wr_mask (ctl_q.jmask),
        .wr_data (ctl_q.jdata),
        .rd_addr (rd_word),
        .rd_data (rd_data)
    );

    always_comb begin
        ctl_d      = ctl_q;
        tmr_start  = 1'b0;
        tmr_long   = 1'b0;
        sk_rise    = sk_s & ~ctl_q.sk_prev;
        ctl_d.sk_prev = sk_s;
        adr_nx     = {ctl_q.adr[BA-2:0], di_s};
        dat_nx     = {ctl_q.dat[WORD_W-2:0], di_s};
        aw_len     = org_s ? CW'(WA) : CW'(BA);
        dw_len     = org_s ? CW'(WORD_W) : CW'(BYTE_W);
        sub        = org_s ? adr_nx[WA-1:WA-2] : adr_nx[BA-1:BA-2];
        rd_word    = org_s ? adr_nx[WA-1:0] : adr_nx[BA-1:1];
        rd_byte    = adr_nx[0] ? rd_data[WORD_W-1:BYTE_W] : rd_data[BYTE_W-1:0];

        if (!cs_s) begin
            ctl_d.st   = ST_IDLE;
            ctl_d.doe  = 1'b0;
            ctl_d.dout = 1'b0;
            ctl_d.pend = JOB_NONE;
            if (ctl_q.st == ST_HOLD && ctl_q.pend != JOB_NONE && !tmr_busy) begin
                tmr_start   = 1'b1;
                tmr_long    = (ctl_q.pend == JOB_ERAL) || (ctl_q.pend == JOB_WRAL);
                ctl_d.stat  = 1'b1;
                ctl_d.jall  = tmr_long;
                ctl_d.jword = org_s ? ctl_q.adr[WA-1:0] : ctl_q.adr[BA-1:1];
                if (org_s || tmr_long)
                    ctl_d.jmask = '1;
                else
                    ctl_d.jmask = ctl_q.adr[0] ? {{BYTE_W{1'b1}}, {BYTE_W{1'b0}}}
                                               : {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};
                if (ctl_q.pend == JOB_WRITE || ctl_q.pend == JOB_WRAL)
                    ctl_d.jdata = org_s ? ctl_q.dat : {2{ctl_q.dat[BYTE_W-1:0]}};
                else
                    ctl_d.jdata = '1;
            end
        end else if (ctl_q.stat) begin
            if (sk_rise && di_s) begin
                ctl_d.stat = 1'b0;
                ctl_d.doe  = 1'b0;
            end else begin
                ctl_d.doe  = 1'b1;
                ctl_d.dout = ~tmr_busy;
            end
        end else if (sk_rise) begin
            unique case (ctl_q.st)
                ST_IDLE: begin
                    if (di_s) begin
                        ctl_d.st   = ST_OPC;
                        ctl_d.cnt  = '0;
                        ctl_d.pend = JOB_NONE;
                    end
                end
                ST_OPC: begin
                    ctl_d.opc = {ctl_q.opc[0], di_s};
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                    if (ctl_q.cnt == CW'(1)) begin
                        ctl_d.st  = ST_ADDR;
                        ctl_d.cnt = '0;
                    end
                end
                ST_ADDR: begin
                    ctl_d.adr = adr_nx;
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                    if (ctl_q.cnt == aw_len - CW'(1)) begin
                        ctl_d.cnt = '0;
                        ctl_d.st  = ST_HOLD;
                        if (!tmr_busy) begin
                            unique case (ctl_q.opc)
                                OPC_READ: begin
                                    ctl_d.st   = ST_READ;
                                    ctl_d.doe  = 1'b1;
                                    ctl_d.dout = 1'b0;
                                    ctl_d.shr  = org_s ? rd_data : {rd_byte, {BYTE_W{1'b0}}};
                                end
                                OPC_WRITE: begin
                                    ctl_d.st   = ST_DATA;
                                    ctl_d.pend = ctl_q.wen ? JOB_WRITE : JOB_NONE;
                                end
                                OPC_ERASE: ctl_d.pend = ctl_q.wen ? JOB_ERASE : JOB_NONE;
                                default: begin
                                    unique case (sub)
                                        SUB_UNLOCK: ctl_d.wen = 1'b1;
                                        SUB_LOCK:   ctl_d.wen = 1'b0;
                                        SUB_CLRALL: ctl_d.pend = ctl_q.wen ? JOB_ERAL : JOB_NONE;
                                        default: begin
                                            ctl_d.st   = ST_DATA;
                                            ctl_d.pend = ctl_q.wen ? JOB_WRAL : JOB_NONE;
                                        end
                                    endcase
                                end
                            endcase
                        end
                    end
                end
                ST_DATA: begin
                    ctl_d.dat = dat_nx;
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                    if (ctl_q.cnt == dw_len - CW'(1)) ctl_d.st = ST_HOLD;
                end
                ST_READ: begin
                    if (ctl_q.cnt == dw_len) begin
                        ctl_d.doe = 1'b0;
                        ctl_d.st  = ST_HOLD;
                    end else begin
                        ctl_d.dout = ctl_q.shr[WORD_W-1];
                        ctl_d.shr  = {ctl_q.shr[WORD_W-2:0], 1'b0};
                        ctl_d.cnt  = ctl_q.cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign dout    = ctl_q.dout;
    assign dout_en = ctl_q.doe;

    // R11: dropping chip select always releases the output
    a_r11_release_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> !dout_en);
    // R4: no programming cycle is ever launched while writes are locked
    a_r4_start_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_start |-> ctl_q.wen);
    // R9: pending status keeps the output driven until the release bit arrives
    a_r9_status_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && ctl_q.stat && !(sk_rise && di_s)) |=> dout_en);
endmodule

// File: tb/mw_eeprom_tb_top.sv
module mw_eeprom_tb_top;
    localparam int T_WORD = 1000;
    localparam int T_ALL  = 2000;
    localparam int H      = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
    logic dout, dout_en;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] mb [128];

    always #2.5 clk = ~clk;

    mw_eeprom #(.T_WORD(T_WORD), .T_ALL(T_ALL)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
        .org_x16(org), .dout(dout), .dout_en(dout_en)
    );

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        finish_up();
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic int aw(); return org ? 6 : 7; endfunction
    function automatic int dw(); return org ? 16 : 8; endfunction

    function automatic logic [15:0] exp_at(input logic [6:0] a);
        if (org) return {mb[{a[5:0], 1'b1}], mb[{a[5:0], 1'b0}]};
        return {8'h00, mb[a]};
    endfunction

    task automatic mdl_write(input logic [6:0] a, input logic [15:0] d);
        if (org) begin
            mb[{a[5:0], 1'b0}] = d[7:0];
            mb[{a[5:0], 1'b1}] = d[15:8];
        end else mb[a] = d[7:0];
    endtask

    task automatic bit_io(input logic b, output logic o, output logic oe);
        di = b;
        repeat (H) @(negedge clk);
        sk = 1'b1;
        repeat (H) @(negedge clk);
        o = dout; oe = dout_en;
        sk = 1'b0;
    endtask

    task automatic send(input logic [15:0] v, input int n, output logic o, output logic oe);
        for (int i = n - 1; i >= 0; i--) bit_io(v[i], o, oe);
    endtask

    task automatic cs_up();
        cs = 1'b1;
        repeat (H) @(negedge clk);
    endtask

    task automatic cs_down();
        sk = 1'b0;
        repeat (H) @(negedge clk);
        cs = 1'b0;
        repeat (3 * H) @(negedge clk);
    endtask

    task automatic frame(input logic [1:0] op, input logic [6:0] a, output logic o, output logic oe);
        bit_io(1'b1, o, oe);
        send({14'd0, op}, 2, o, oe);
        send({9'd0, a}, aw(), o, oe);
    endtask

    task automatic rd(input logic [6:0] a, input int lz, input string tag, output logic [15:0] v);
        logic o, oe;
        int en_ok;
        cs_up();
        if (lz > 0) send(16'd0, lz, o, oe);
        frame(2'b10, a, o, oe);
        chk(oe && !o, {tag, " R3 dummy zero"}, {oe, o}, 2'b10);
        v = '0; en_ok = 1;
        for (int i = 0; i < dw(); i++) begin
            bit_io(1'b0, o, oe);
            v = {v[14:0], o};
            if (!oe) en_ok = 0;
        end
        chk(en_ok == 1, {tag, " R3 enable during data"}, en_ok, 1);
        bit_io(1'b0, o, oe);
        chk(!oe, {tag, " R3 release after last bit"}, oe, 0);
        cs_down();
    endtask

    task automatic rd_chk(input logic [6:0] a, input string tag);
        logic [15:0] v;
        rd(a, 0, tag, v);
        chk(v == exp_at(a), tag, v, exp_at(a));
    endtask

    task automatic cmd(input logic [1:0] op, input logic [6:0] a, input bit has_d, input logic [15:0] d);
        logic o, oe;
        cs_up();
        frame(op, a, o, oe);
        if (has_d) send(d, dw(), o, oe);
        cs_down();
    endtask

    task automatic ext(input logic [1:0] sub, input bit has_d, input logic [15:0] d);
        logic [6:0] a;
        a = 7'({sub, 5'd0} >> (7 - aw()));
        cmd(2'b00, a, has_d, d);
    endtask

    task automatic status_seq(input int t, input string tag);
        logic o, oe;
        cs_up();
        chk(dout_en && !dout, {tag, " R9 busy early"}, {dout_en, dout}, 2'b10);
        repeat (t - 200) @(negedge clk);
        chk(dout_en && !dout, {tag, " R8 still busy"}, {dout_en, dout}, 2'b10);
        repeat (300) @(negedge clk);
        chk(dout_en && dout, {tag, " R8 ready after cycle"}, {dout_en, dout}, 2'b11);
        bit_io(1'b1, o, oe);
        chk(!oe, {tag, " R9 dummy one releases"}, oe, 0);
        cs_down();
    endtask

    task automatic no_status(input string tag);
        cs_up();
        repeat (H) @(negedge clk);
        chk(!dout_en, {tag, " no cycle started"}, dout_en, 0);
        cs_down();
    endtask

    initial begin
        logic [15:0] v;
        logic o, oe;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 128; i++) mb[i] = 8'hFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        chk(!dout_en, "R1 output released at reset", dout_en, 0);
        rd_chk(7'd5, "R1 erased contents");

        cmd(2'b01, 7'd5, 1, 16'hA5C3);
        no_status("R4 locked write");
        rd_chk(7'd5, "R4 locked write ignored");

        ext(2'b11, 0, 16'd0);
        no_status("R4 unlock is not a cycle");
        cmd(2'b01, 7'd5, 1, 16'hA5C3);
        status_seq(T_WORD, "R5 write");
        mdl_write(7'd5, 16'hA5C3);
        rd_chk(7'd5, "R5 write stored");

        // R10: erase issued during a busy cycle must be dropped
        cmd(2'b01, 7'd7, 1, 16'h1234);
        cs_up();
        chk(dout_en && !dout, "R10 busy before release", {dout_en, dout}, 2'b10);
        bit_io(1'b1, o, oe);
        frame(2'b11, 7'd5, o, oe);
        cs_down();
        repeat (T_WORD) @(negedge clk);
        mdl_write(7'd7, 16'h1234);
        rd_chk(7'd5, "R10 erase while busy ignored");
        rd_chk(7'd7, "R5 second write");

        // R11: frame cut short by chip select
        cs_up();
        frame(2'b01, 7'd9, o, oe);
        send(16'h00, 8, o, oe);
        cs_down();
        no_status("R11 truncated frame");
        rd_chk(7'd9, "R11 truncated frame discarded");

        rd(7'd5, 3, "R2 leading zeros", v);
        chk(v == 16'hA5C3, "R2 leading zeros skipped", v, 16'hA5C3);

        org = 1'b0;
        rd_chk(7'd10, "R3 byte low lane");
        rd_chk(7'd11, "R3 byte high lane");
        cmd(2'b01, 7'd14, 1, 16'h005A);
        status_seq(T_WORD, "R5 byte write");
        mdl_write(7'd14, 16'h005A);
        org = 1'b1;
        rd_chk(7'd7, "R5 byte write lane");

        cmd(2'b11, 7'd7, 0, 16'd0);
        status_seq(T_WORD, "R6 erase");
        mdl_write(7'd7, 16'hFFFF);
        rd_chk(7'd7, "R6 erase to ones");

        for (int k = 0; k < 10; k++) begin
            logic [6:0] a;
            logic [15:0] d;
            org = 1'($urandom % 2);
            a = 7'($urandom % 128);
            if (org) a[6] = 1'b0;
            d = 16'($urandom);
            cmd(2'b01, a, 1, d);
            status_seq(T_WORD, "R5 random write");
            mdl_write(a, d);
        end
        for (int k = 0; k < 12; k++) begin
            logic [6:0] a;
            org = 1'($urandom % 2);
            a = 7'($urandom % 128);
            if (org) a[6] = 1'b0;
            rd_chk(a, "R5 random readback");
        end

        org = 1'b1;
        ext(2'b10, 0, 16'd0);
        status_seq(T_ALL, "R6 erase all");
        for (int i = 0; i < 128; i++) mb[i] = 8'hFF;
        rd_chk(7'd0, "R6 erase all first");
        rd_chk(7'd63, "R6 erase all last");

        ext(2'b01, 1, 16'hBEEF);
        status_seq(T_ALL, "R7 fill words");
        for (int i = 0; i < 64; i++) mdl_write(7'(i), 16'hBEEF);
        rd_chk(7'd0, "R7 fill words first");
        rd_chk(7'd40, "R7 fill words middle");

        org = 1'b0;
        ext(2'b01, 1, 16'h003C);
        status_seq(T_ALL, "R7 fill bytes");
        for (int i = 0; i < 128; i++) mb[i] = 8'h3C;
        org = 1'b1;
        rd_chk(7'd20, "R7 fill bytes both lanes");

        ext(2'b00, 0, 16'd0);
        cmd(2'b01, 7'd3, 1, 16'h0000);
        no_status("R4 relocked write");
        rd_chk(7'd3, "R4 relocked write ignored, read allowed");
        ext(2'b10, 0, 16'd0);
        no_status("R4 relocked erase all");
        rd_chk(7'd3, "R4 relocked erase all ignored");

        finish_up();
    end
endmodule